// File: doc/BRIEF.md
# LIN Auto-Baud Synchronization Unit

This block sets the bit timing of a LIN slave from the bus itself. Once a synch break has been flagged and auto-sync is enabled, it times the synch byte. The synch byte is a 0x55 with its start and stop bits, so its falling edges sit two bit periods apart. The block counts system clocks from the first falling edge on the receive line to the fifth. That span is eight bit periods. From the count it derives a new baud divisor in unsigned 8.4 fixed point.

The divisor feeds a fractional tick generator. The generator emits the 16x oversampling tick that paces both the transmitter and the receiver in slave mode. Software loads a nominal divisor, and that value stays in force until a measurement completes. While a measurement runs, a busy flag holds the frame state machine stopped.

Top module: `lin_autobaud`

## Requirements
- R1: After reset, div_o is 0x100 (16.0), and busy_o, upd_o, err_o and tick_o are low.
- R2: A cycle with div_wr_i high loads div_wdata_i into div_o, visible from the next cycle.
- R3: A measurement is armed only in a cycle where brk_det_i and auto_en_i are both high. A break with auto_en_i low leaves busy_o low, and a following synch pattern leaves div_o unchanged and raises no upd_o.
- R4: The measured count is the number of clock edges from the one that samples the first falling edge of rx_i to the one that samples the fifth. A falling edge is rx_i low in a cycle where it was high in the cycle before.
- R5: At the fifth falling edge, div_o takes min((count + 4) >> 3, 0xFFF), that is, count/128 rounded to the nearest 1/16. In the same cycle upd_o pulses high for one cycle.
- R6: busy_o is high from the cycle after arming until the cycle after the fifth falling edge or an abort. Falling edges seen while not busy have no effect.
- R7: If the 15-bit count reaches 32767 before the fifth falling edge, the measurement aborts. err_o pulses for one cycle, busy_o drops and div_o keeps its previous value.
- R8: A break with auto-sync enabled that arrives during a measurement restarts it. Only edges after the re-arm count.
- R9: With slave_i high, tick_o pulses exactly floor(16·M / max(div_o, 0x010)) times in the M cycles that follow enabling, using an accumulator that starts at zero. Divisors below 1.0 therefore tick every cycle.
- R10: With slave_i low, tick_o stays low and the tick accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, already synchronized |
| brk_det_i | input | 1 | One-cycle pulse: synch break detected |
| auto_en_i | input | 1 | Auto-sync enable |
| slave_i | input | 1 | Slave mode; enables the tick generator |
| div_wr_i | input | 1 | Software write strobe for the divisor |
| div_wdata_i | input | 12 | Nominal divisor, 8.4 fixed point |
| div_o | output | 12 | Current divisor, 8.4 fixed point |
| tick_o | output | 1 | 16x oversampling tick |
| upd_o | output | 1 | One-cycle pulse when a measured divisor is loaded |
| busy_o | output | 1 | Measurement in progress; holds off the frame state machine |
| err_o | output | 1 | One-cycle pulse on measurement overflow abort |

## Verification
The bench drives inputs at the falling clock edge, so every change is sampled at the next rising edge. A divisor write is visible at the following falling edge, and so is busy_o after a break pulse. After the fifth falling edge is driven, the bench waits exactly one rising edge and then checks div_o, upd_o and busy_o. Pattern segments are counted in whole cycles, so the reference count is the sum of the segment lengths. For tick_o, slave_i is raised at a falling edge and tick_o is sampled once after each of the next M rising edges. The sum is compared with floor(16·M/divisor) from a bench function.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_WAIT  = 2'd1,
    MS_COUNT = 2'd2
  } meas_state_e;
endpackage

// File: rtl/lin_ab_meas.sv
module lin_ab_meas
  import lin_ab_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int DIV_W     = 12,
  parameter int FRAC_W    = 4,
  parameter int SPAN_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             arm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o,
  output logic [DIV_W-1:0] res_o
);
  localparam int EDGE_N = SPAN_BITS / 2 + 1;
  localparam int EW     = $clog2(EDGE_N);
  localparam int SHIFT  = $clog2(SPAN_BITS * OVS) - FRAC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   HALF    = (CNT_W+1)'(1 << (SHIFT - 1));
  localparam logic [CNT_W:0]   RES_MAX = (CNT_W+1)'((1 << DIV_W) - 1);

  meas_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    edg_q;
  logic             rx_q;
  logic             fall;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   quo;

  assign fall    = rx_q & ~rx_i;
  assign done_o  = (state_q == MS_COUNT) && fall && (edg_q == EW'(EDGE_N - 1)) && !arm_i;
  assign abort_o = (state_q == MS_COUNT) && (cnt_q == CNT_MAX) && !done_o && !arm_i;
  assign busy_o  = (state_q != MS_IDLE);

  // round to nearest 1/16, clamp to divisor range
  assign sum   = {1'b0, cnt_q} + HALF;
  assign quo   = sum >> SHIFT;
  assign res_o = (quo > RES_MAX) ? RES_MAX[DIV_W-1:0] : quo[DIV_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      edg_q   <= '0;
    end else if (arm_i) begin
      state_q <= MS_WAIT;
      cnt_q   <= '0;
      edg_q   <= '0;
    end else begin
      unique case (state_q)
        MS_WAIT: if (fall) begin
          state_q <= MS_COUNT;
          cnt_q   <= CNT_W'(1);
          edg_q   <= EW'(1);
        end
        MS_COUNT: begin
          if (done_o || abort_o) begin
            state_q <= MS_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (fall) edg_q <= edg_q + EW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  a_r6_busy_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(arm_i));
  a_r7_abort_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !busy_o || $past(arm_i));
  a_r5_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o || $past(arm_i));
  a_r6_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !arm_i |=> !busy_o);
endmodule

// File: rtl/lin_ab_divreg.sv
module lin_ab_divreg #(
  parameter int          DIV_W   = 12,
  parameter logic [11:0] DIV_RST = 12'h100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] wdata_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] ldata_i,
  output logic [DIV_W-1:0] div_o,
  output logic             upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= DIV_W'(DIV_RST);
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i)    div_o <= ldata_i;
      else if (wr_i) div_o <= wdata_i;
    end
  end

  a_r2_div_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> $past(wr_i) || $past(load_i));
  a_r5_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o && !load_i |=> !upd_o);
endmodule

// File: rtl/lin_ab_tick.sv
module lin_ab_tick #(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int AW = DIV_W + 1;
  localparam logic [AW-1:0] STEP = AW'(1 << FRAC_W);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] eff;
  logic [AW-1:0] sum;

  assign eff = ({1'b0, div_i} < STEP) ? STEP : {1'b0, div_i};
  assign sum = acc_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (sum >= eff) begin
      acc_q  <= sum - eff;  // carry remainder, no drift
      tick_o <= 1'b1;
    end else begin
      acc_q  <= sum;
      tick_o <= 1'b0;
    end
  end

  a_r10_tick_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !tick_o);
  a_r9_min_div_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && ($past(div_i) <= DIV_W'(STEP)) && ($past(acc_q) == '0) |-> tick_o);
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int          CNT_W     = 15,
  parameter int          INT_W     = 8,
  parameter int          FRAC_W    = 4,
  parameter int          SPAN_BITS = 8,
  parameter int          OVS       = 16,
  parameter logic [11:0] DIV_RST   = 12'h100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic        brk_det_i,
  input  logic        auto_en_i,
  input  logic        slave_i,
  input  logic        div_wr_i,
  input  logic [11:0] div_wdata_i,
  output logic [11:0] div_o,
  output logic        tick_o,
  output logic        upd_o,
  output logic        busy_o,
  output logic        err_o
);
  localparam int DIV_W = INT_W + FRAC_W;

  logic             arm;
  logic             done;
  logic             abort;
  logic [DIV_W-1:0] res;
  logic [DIV_W-1:0] div;

  assign arm   = brk_det_i & auto_en_i;
  assign div_o = 12'(div);

  lin_ab_meas #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W),
    .SPAN_BITS(SPAN_BITS), .OVS(OVS)
  ) u_meas (
    .clk_i, .rst_ni, .rx_i, .arm_i(arm),
    .busy_o, .done_o(done), .abort_o(abort), .res_o(res)
  );

  lin_ab_divreg #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk_i, .rst_ni,
    .wr_i(div_wr_i), .wdata_i(DIV_W'(div_wdata_i)),
    .load_i(done), .ldata_i(res),
    .div_o(div), .upd_o
  );

  lin_ab_tick #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_tick (
    .clk_i, .rst_ni, .en_i(slave_i), .div_i(div), .tick_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= abort;
  end

  a_r3_no_arm_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i && !busy_o |=> !busy_o);
  a_r7_err_keeps_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !$past(div_wr_i) |-> $stable(div_o) && !upd_o);
endmodule

// File: tb/tb_lin_autobaud.sv
module tb_lin_autobaud;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1, brk = 1'b0, auto_en = 1'b0, slave = 1'b0, wr = 1'b0;
  logic [11:0] wdata = '0;
  logic [11:0] div;
  logic        tick, upd, busy, err;

  int n_chk = 0, n_fail = 0;
  int upd_seen = 0, err_seen = 0;
  int seg [8];
  bit done_flag = 0;

  always #5 clk = ~clk;

  lin_autobaud dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .brk_det_i(brk), .auto_en_i(auto_en),
    .slave_i(slave), .div_wr_i(wr), .div_wdata_i(wdata),
    .div_o(div), .tick_o(tick), .upd_o(upd), .busy_o(busy), .err_o(err)
  );

  always @(negedge clk) begin
    if (upd) upd_seen++;
    if (err) err_seen++;
  end

  function automatic int exp_div(int cnt);
    int q = (cnt + 4) >> 3;
    return (q > 4095) ? 4095 : q;
  endfunction

  function automatic int exp_ticks(int m, int d);
    int e = (d < 16) ? 16 : d;
    return (16 * m) / e;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sw_write(int v);
    @(negedge clk); wr = 1'b1; wdata = 12'(v);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic break_pulse();
    @(negedge clk); brk = 1'b1;
    @(negedge clk); brk = 1'b0;
  endtask

  // drives eight synch segments then the fifth fall; returns the span count
  task automatic send_sync(output int cnt);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      rx = i[0];
      repeat (seg[i]) @(negedge clk);
      cnt += seg[i];
    end
    rx = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_frame();
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure_check(string tag, int old_div, bit expect_upd);
    int cnt;
    int u0;
    u0 = upd_seen;
    send_sync(cnt);
    if (expect_upd) begin
      chk({tag, " R5 div"}, div, exp_div(cnt));
      chk({tag, " R5 upd"}, upd, 1);
      chk({tag, " R6 busy low"}, busy, 0);
    end else begin
      chk({tag, " R3 div kept"}, div, old_div);
      chk({tag, " R3 no upd"}, upd_seen - u0, 0);
    end
    finish_frame();
  endtask

  task automatic tick_window(int d, int m);
    int t = 0;
    @(negedge clk); slave = 1'b0;
    sw_write(d);
    @(negedge clk); slave = 1'b1;
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      t += tick;
    end
    chk("R9 tick count", t, exp_ticks(m, d));
    slave = 1'b0;
    @(negedge clk);
    chk("R10 tick off", tick, 0);
  endtask

  initial begin
    int bp;
    int d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 div reset", div, 12'h100);
    chk("R1 busy", busy, 0);
    chk("R1 upd", upd, 0);
    chk("R1 err", err, 0);
    chk("R1 tick", tick, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    sw_write(12'h2A7);
    chk("R2 sw write", div, 12'h2A7);

    // R3: break without enable
    auto_en = 1'b0;
    break_pulse();
    chk("R3 busy stays low", busy, 0);
    for (int i = 0; i < 8; i++) seg[i] = 20;
    measure_check("no-enable", 12'h2A7, 0);

    // R6: edges while idle ignored even with enable
    auto_en = 1'b1;
    measure_check("idle-edges", 12'h2A7, 0);

    // R4 R5 R6: random bit periods with jitter
    for (int n = 0; n < 10; n++) begin
      bp = 4 + int'($urandom_range(0, 60));
      for (int i = 0; i < 8; i++) seg[i] = bp + int'($urandom_range(0, 3)) - 1;
      break_pulse();
      chk("R6 busy after arm", busy, 1);
      repeat (2) @(negedge clk);
      measure_check("random", 0, 1);
    end

    // directed: short bit, rounding boundary counts
    for (int i = 0; i < 8; i++) seg[i] = 1;
    break_pulse();
    measure_check("minimal R4", 0, 1);
    seg = '{3, 3, 3, 3, 3, 3, 3, 0};
    seg[7] = 2;  // cnt 23 -> (27>>3)=3
    break_pulse();
    measure_check("round-down R5", 0, 1);
    seg[7] = 1;  // cnt 22 -> 26>>3 = 3; cnt 20 -> 3 (round up from 2.5)
    seg[6] = 1;
    break_pulse();
    measure_check("round-half R5", 0, 1);

    // R5 clamp at 0xFFF
    seg = '{4096, 4096, 4096, 4096, 4095, 4095, 4095, 4095};
    break_pulse();
    measure_check("clamp R5", 0, 1);
    chk("R5 clamp value", div, 12'hFFF);

    // R8: re-arm restarts
    sw_write(12'h150);
    break_pulse();
    rx = 1'b0; repeat (30) @(negedge clk);
    rx = 1'b1; repeat (30) @(negedge clk);
    rx = 1'b0; repeat (30) @(negedge clk);
    rx = 1'b1;
    break_pulse();
    chk("R8 busy after re-arm", busy, 1);
    for (int i = 0; i < 8; i++) seg[i] = 9;
    measure_check("rearm R8", 0, 1);
    chk("R8 second span", div, exp_div(72));

    // R7: overflow abort
    d = div;
    err_seen = 0;
    break_pulse();
    rx = 1'b0; repeat (10) @(negedge clk);
    rx = 1'b1; repeat (32800) @(negedge clk);
    chk("R7 err pulse count", err_seen, 1);
    chk("R7 busy dropped", busy, 0);
    chk("R7 div kept", div, d);

    // R9 R10 tick generator
    tick_window(12'h010, 200);
    tick_window(12'h008, 100);
    tick_window(12'h018, 300);
    tick_window(12'h100, 640);
    for (int n = 0; n < 4; n++) tick_window(16 + int'($urandom_range(0, 500)), 700);
    chk("R10 tick low idle", tick, 0);

    done_flag = 1;
  end

  initial begin
    fork
      begin
        wait (done_flag);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule